// File: doc/BRIEF.md
# Doorbell Mailbox Channel Unit

This block lets one processor ring doorbells on another. It has two register
frames, each a 32-bit memory-mapped bank on its own simple valid/ready bus. The
sending side owns the sender frame. It ORs flag bits into the 32-bit status word
of a channel. The receiving side owns the receiver frame. It reads those flags,
masks some of them and clears them. A level interrupt stays high while any
unmasked flag is pending on any channel.

Before the sender may ring, it raises an access request and waits for access
ready. That handshake models the far side waking up. Ready follows the request
after a fixed, parameterised number of cycles. Flag-set writes made while ready
is low are dropped. Both frames report how many channels are implemented and
carry an architecture identification word. When the minor revision parameter is
1, the sender frame also has a small interrupt block that latches the rising
edge of access ready.

Top module: `doorbell_mbox`

## Requirements
- R1: After reset, every channel status and mask is zero, and `acc_ready`, `snd_irq` and `rcv_irq` are low.
- R2: A sender write to channel window offset 0x0C, with the window at byte address ch*0x20, ORs its data into that channel's status. The write only takes effect while access ready is high; otherwise it is ignored. The status reads back at offset 0x00 of the window in both frames.
- R3: A receiver write to window offset 0x08 ANDs the status with the inverse of its data, so all ones empties the channel. When a set and a clear reach the same channel in one cycle, the clear wins on overlapping bits.
- R4: Receiver offset 0x14 ORs data into the channel mask and offset 0x18 removes bits from it. Offset 0x10 reads the mask, and offset 0x04 reads status AND NOT mask.
- R5: `rcv_irq` is high exactly when some channel has a non-zero masked status.
- R6: Bit 0 of sender address 0xF88 is a read/write access request. Access ready reads at 0xF8C bit 0 and drives `acc_ready`. It rises ACC_DELAY cycles after the clock edge that stores a request of 1, and falls right after the edge that stores 0.
- R7: Address 0xF80 in both frames reads NUM_CH. Address 0xFCC reads 1 in bits 7:4 and MINOR_REV in bits 3:0.
- R8: With MINOR_REV = 1, bit 0 of sender 0xF90 is set on each rising edge of access ready. Writing 1 to bit 0 of 0xF94 clears it, and 0xF98 bit 0 is a read/write enable. `snd_irq` is status AND enable. With MINOR_REV = 0, these addresses read zero.
- R9: Reserved window offsets, channel windows at or above NUM_CH and unlisted addresses read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_valid | input | 1 | Sender bus request valid |
| snd_write | input | 1 | Sender bus write (1) or read (0) |
| snd_addr | input | 12 | Sender bus byte address |
| snd_wdata | input | 32 | Sender bus write data |
| snd_ready | output | 1 | Sender bus accept, always high |
| snd_rdata | output | 32 | Sender bus read data, same cycle |
| rcv_valid | input | 1 | Receiver bus request valid |
| rcv_write | input | 1 | Receiver bus write (1) or read (0) |
| rcv_addr | input | 12 | Receiver bus byte address |
| rcv_wdata | input | 32 | Receiver bus write data |
| rcv_ready | output | 1 | Receiver bus accept, always high |
| rcv_rdata | output | 32 | Receiver bus read data, same cycle |
| acc_ready | output | 1 | Access ready (far side awake) |
| snd_irq | output | 1 | Sender interrupt, ready-rise event |
| rcv_irq | output | 1 | Receiver doorbell interrupt |

## Verification
Every channel is rung with a walking-bit pattern mixed with a shifted constant, so a channel crossover or a lost OR term changes the word read back in both frames. Partial clears, mask patterns and a colliding set/clear pair separate clear priority from set priority and masked status from raw status. The wake delay is sampled one cycle before and on the expected edge, which exposes an off-by-one counter. Probes of reserved offsets and of the first missing channel window show up any decode aliasing.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] CFG_ADDR    = 12'hF80;
  localparam logic [AW-1:0] REQ_ADDR    = 12'hF88;
  localparam logic [AW-1:0] RDY_ADDR    = 12'hF8C;
  localparam logic [AW-1:0] IST_ADDR    = 12'hF90;
  localparam logic [AW-1:0] ICLR_ADDR   = 12'hF94;
  localparam logic [AW-1:0] IEN_ADDR    = 12'hF98;
  localparam logic [AW-1:0] ARCH_ADDR   = 12'hFCC;

  // window word offsets (addr[4:2])
  localparam logic [2:0] W_STAT  = 3'd0;
  localparam logic [2:0] W_MSTAT = 3'd1;
  localparam logic [2:0] W_CLR   = 3'd2;
  localparam logic [2:0] W_SET   = 3'd3;
  localparam logic [2:0] W_MASK  = 3'd4;
  localparam logic [2:0] W_MSET  = 3'd5;
  localparam logic [2:0] W_MCLR  = 3'd6;

  function automatic logic [DW-1:0] flag_next(input logic [DW-1:0] cur,
                                               input logic set_we, input logic [DW-1:0] set_d,
                                               input logic clr_we, input logic [DW-1:0] clr_d);
    logic [DW-1:0] s, c;
    s = set_we ? set_d : '0;
    c = clr_we ? clr_d : '0;
    return (cur | s) & ~c;
  endfunction

  function automatic logic [DW-1:0] arch_word(input int unsigned minor);
    return {24'd0, 4'd1, 4'(minor)};
  endfunction

  function automatic logic in_window(input logic [AW-1:0] a, input int unsigned nch);
    return (a < CFG_ADDR) && (int'(a[AW-1:5]) < nch);
  endfunction

  function automatic logic same_word(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:2] == b[AW-1:2];
  endfunction
endpackage

// File: rtl/dbm_wake.sv
module dbm_wake #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic rdy,
  output logic rdy_rise
);
  localparam int unsigned CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DELAY);

  logic [CW-1:0] cnt;
  logic          rdy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rdy_d <= 1'b0;
    end else begin
      rdy_d <= rdy;
      if (!req)            cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end
  end

  assign rdy      = req && (cnt == LIMIT);
  assign rdy_rise = rdy && !rdy_d;

  // R6
  rdy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !rdy);
  // R6
  rdy_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(req));
endmodule

// File: rtl/dbm_chan_cell.sv
module dbm_chan_cell
  import dbm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic [DW-1:0] set_d,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_d,
  input  logic          mset_we,
  input  logic          mclr_we,
  input  logic [DW-1:0] mdata,
  output logic [DW-1:0] status,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] masked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
    end else begin
      status <= flag_next(status, set_we, set_d, clr_we, clr_d);
      if (mset_we)      mask <= mask | mdata;
      else if (mclr_we) mask <= mask & ~mdata;
    end
  end

  assign masked = status & ~mask;

  // R3
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> (status & $past(clr_d)) == '0);
  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_we |=> (status & ~$past(status)) == '0);
  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_we && !mset_we |=> (mask & $past(mdata)) == '0);
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import dbm_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned ACC_DELAY = 4,
  parameter int unsigned MINOR_REV = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          snd_valid,
  input  logic          snd_write,
  input  logic [11:0]   snd_addr,
  input  logic [31:0]   snd_wdata,
  output logic          snd_ready,
  output logic [31:0]   snd_rdata,
  input  logic          rcv_valid,
  input  logic          rcv_write,
  input  logic [11:0]   rcv_addr,
  input  logic [31:0]   rcv_wdata,
  output logic          rcv_ready,
  output logic [31:0]   rcv_rdata,
  output logic          acc_ready,
  output logic          snd_irq,
  output logic          rcv_irq
);
  localparam logic [DW-1:0] CFG_WORD = DW'(NUM_CH);
  localparam logic [DW-1:0] ARCH_WORD = arch_word(MINOR_REV);

  // decode
  logic [6:0] s_ch, r_ch;
  logic [2:0] s_off, r_off;
  logic       s_win, r_win, s_wr, r_wr, s_rd, r_rd;

  assign s_ch  = snd_addr[11:5];
  assign r_ch  = rcv_addr[11:5];
  assign s_off = snd_addr[4:2];
  assign r_off = rcv_addr[4:2];
  assign s_win = in_window(snd_addr, NUM_CH);
  assign r_win = in_window(rcv_addr, NUM_CH);
  assign s_wr  = snd_valid && snd_write;
  assign r_wr  = rcv_valid && rcv_write;
  assign s_rd  = snd_valid && !snd_write;
  assign r_rd  = rcv_valid && !rcv_write;

  assign snd_ready = 1'b1;
  assign rcv_ready = 1'b1;

  // access request / wake handshake
  logic req_q, rdy_rise;
  logic req_wr;
  assign req_wr = s_wr && same_word(snd_addr, REQ_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (req_wr) req_q <= snd_wdata[0];
  end

  dbm_wake #(.DELAY(ACC_DELAY)) u_wake (
    .clk(clk), .rst_n(rst_n), .req(req_q), .rdy(acc_ready), .rdy_rise(rdy_rise)
  );

  // named events for channel access
  logic s_set_hit, s_set_blocked;
  assign s_set_hit     = s_wr && s_win && (s_off == W_SET);
  assign s_set_blocked = s_set_hit && !acc_ready;

  logic [NUM_CH-1:0] set_we, clr_we, mset_we, mclr_we;
  logic [DW-1:0]     st   [NUM_CH];
  logic [DW-1:0]     mk   [NUM_CH];
  logic [DW-1:0]     mst  [NUM_CH];
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH*DW-1:0] st_flat;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign set_we[g]  = s_set_hit && acc_ready && (int'(s_ch) == g);
    assign clr_we[g]  = r_wr && r_win && (r_off == W_CLR)  && (int'(r_ch) == g);
    assign mset_we[g] = r_wr && r_win && (r_off == W_MSET) && (int'(r_ch) == g);
    assign mclr_we[g] = r_wr && r_win && (r_off == W_MCLR) && (int'(r_ch) == g);

    dbm_chan_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_we(set_we[g]), .set_d(snd_wdata),
      .clr_we(clr_we[g]), .clr_d(rcv_wdata),
      .mset_we(mset_we[g]), .mclr_we(mclr_we[g]), .mdata(rcv_wdata),
      .status(st[g]), .mask(mk[g]), .masked(mst[g])
    );
    assign pend[g] = |mst[g];
    assign st_flat[g*DW +: DW] = st[g];
  end

  assign rcv_irq = |pend;

  // sender interrupt block, present only with minor revision 1
  logic int_st, int_en;
  if (MINOR_REV == 1) begin : g_int
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        int_st <= 1'b0;
        int_en <= 1'b0;
      end else begin
        if (rdy_rise)
          int_st <= 1'b1;
        else if (s_wr && same_word(snd_addr, ICLR_ADDR) && snd_wdata[0])
          int_st <= 1'b0;
        if (s_wr && same_word(snd_addr, IEN_ADDR))
          int_en <= snd_wdata[0];
      end
    end
  end else begin : g_noint
    assign int_st = 1'b0;
    assign int_en = 1'b0;
  end

  assign snd_irq = int_st && int_en;

  // channel selection for reads
  logic [DW-1:0] s_sel_st, r_sel_st, r_sel_mk, r_sel_mst;
  always_comb begin
    s_sel_st  = '0;
    r_sel_st  = '0;
    r_sel_mk  = '0;
    r_sel_mst = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(s_ch) == i) s_sel_st = st[i];
      if (int'(r_ch) == i) begin
        r_sel_st  = st[i];
        r_sel_mk  = mk[i];
        r_sel_mst = mst[i];
      end
    end
  end

  always_comb begin
    snd_rdata = '0;
    if (s_rd) begin
      if (s_win) begin
        if (s_off == W_STAT) snd_rdata = s_sel_st;
      end else if (same_word(snd_addr, CFG_ADDR))  snd_rdata = CFG_WORD;
      else if (same_word(snd_addr, REQ_ADDR))  snd_rdata = {31'd0, req_q};
      else if (same_word(snd_addr, RDY_ADDR))  snd_rdata = {31'd0, acc_ready};
      else if (same_word(snd_addr, IST_ADDR))  snd_rdata = {31'd0, int_st};
      else if (same_word(snd_addr, IEN_ADDR))  snd_rdata = {31'd0, int_en};
      else if (same_word(snd_addr, ARCH_ADDR)) snd_rdata = ARCH_WORD;
    end
  end

  always_comb begin
    rcv_rdata = '0;
    if (r_rd) begin
      if (r_win) begin
        case (r_off)
          W_STAT:  rcv_rdata = r_sel_st;
          W_MSTAT: rcv_rdata = r_sel_mst;
          W_MASK:  rcv_rdata = r_sel_mk;
          default: rcv_rdata = '0;
        endcase
      end else if (same_word(rcv_addr, CFG_ADDR))  rcv_rdata = CFG_WORD;
      else if (same_word(rcv_addr, ARCH_ADDR)) rcv_rdata = ARCH_WORD;
    end
  end

  // R2
  gated_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_set_blocked && !(|clr_we) |=> $stable(st_flat));
  // R5
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|st_flat) == 1'b0 |-> !rcv_irq);
  // R8
  snd_irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_irq |-> $past(int_en) || $past(s_wr));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !acc_ready && !rcv_irq && !snd_irq);
endmodule

// File: tb/sim_doorbell_mbox.sv
module sim_doorbell_mbox;
  localparam int NCH = 4;
  localparam int DLY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic        snd_valid = 0, snd_write = 0, rcv_valid = 0, rcv_write = 0;
  logic [11:0] snd_addr = 0, rcv_addr = 0;
  logic [31:0] snd_wdata = 0, rcv_wdata = 0;
  logic        snd_ready, rcv_ready, acc_ready, snd_irq, rcv_irq;
  logic [31:0] snd_rdata, rcv_rdata;

  int tests = 0;
  int fails = 0;
  logic [31:0] e_st [NCH];
  logic [31:0] e_mk [NCH];

  always #2 clk = ~clk;

  doorbell_mbox #(.NUM_CH(NCH), .ACC_DELAY(DLY), .MINOR_REV(1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .snd_valid(snd_valid), .snd_write(snd_write), .snd_addr(snd_addr),
    .snd_wdata(snd_wdata), .snd_ready(snd_ready), .snd_rdata(snd_rdata),
    .rcv_valid(rcv_valid), .rcv_write(rcv_write), .rcv_addr(rcv_addr),
    .rcv_wdata(rcv_wdata), .rcv_ready(rcv_ready), .rcv_rdata(rcv_rdata),
    .acc_ready(acc_ready), .snd_irq(snd_irq), .rcv_irq(rcv_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic s_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    snd_valid = 1; snd_write = 1; snd_addr = a; snd_wdata = d;
    @(posedge clk); #1;
    snd_valid = 0; snd_write = 0;
  endtask

  task automatic r_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    rcv_valid = 1; rcv_write = 1; rcv_addr = a; rcv_wdata = d;
    @(posedge clk); #1;
    rcv_valid = 0; rcv_write = 0;
  endtask

  task automatic both_wr(input logic [11:0] sa, input logic [31:0] sd,
                         input logic [11:0] ra, input logic [31:0] rd);
    @(negedge clk);
    snd_valid = 1; snd_write = 1; snd_addr = sa; snd_wdata = sd;
    rcv_valid = 1; rcv_write = 1; rcv_addr = ra; rcv_wdata = rd;
    @(posedge clk); #1;
    snd_valid = 0; snd_write = 0; rcv_valid = 0; rcv_write = 0;
  endtask

  task automatic s_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    snd_valid = 1; snd_write = 0; snd_addr = a;
    #1 d = snd_rdata;
    snd_valid = 0;
  endtask

  task automatic r_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rcv_valid = 1; rcv_write = 0; rcv_addr = a;
    #1 d = rcv_rdata;
    rcv_valid = 0;
  endtask

  function automatic logic [11:0] win(input int ch, input int off);
    return 12'(ch * 32 + off);
  endfunction

  // bench model of an update: bits cleared win, rest keep old or new ones
  function automatic logic [31:0] model_upd(input logic [31:0] cur,
                                            input logic [31:0] s, input logic [31:0] c);
    return (cur & ~c) | (s & ~c);
  endfunction

  function automatic logic any_pending();
    logic p = 0;
    for (int i = 0; i < NCH; i++) p = p | ((e_st[i] & ~e_mk[i]) != 0);
    return p;
  endfunction

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int ch = 0; ch < NCH; ch++) begin
      s_rd(win(ch, 'h00), v); chk(req, v, e_st[ch]);
      r_rd(win(ch, 'h00), v); chk(req, v, e_st[ch]);
      r_rd(win(ch, 'h04), v); chk({req, " masked"}, v, e_st[ch] & ~e_mk[ch]);
      r_rd(win(ch, 'h10), v); chk({req, " mask"}, v, e_mk[ch]);
    end
    chk({req, " R5 irq"}, {31'd0, rcv_irq}, {31'd0, any_pending()});
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NCH; i++) begin e_st[i] = 0; e_mk[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 acc_ready", {31'd0, acc_ready}, 0);
    chk("R1 rcv_irq", {31'd0, rcv_irq}, 0);
    chk("R1 snd_irq", {31'd0, snd_irq}, 0);
    check_all("R1");

    // R7 config and architecture words
    s_rd(12'hF80, v); chk("R7 snd cfg", v, NCH);
    r_rd(12'hF80, v); chk("R7 rcv cfg", v, NCH);
    s_rd(12'hFCC, v); chk("R7 snd arch", v, 32'h11);
    r_rd(12'hFCC, v); chk("R7 rcv arch", v, 32'h11);

    // R2 set ignored without ready
    s_wr(win(1, 'h0C), 32'hFFFF_0000);
    check_all("R2 gated");

    // R6 request and wake timing
    s_wr(12'hF88, 1);
    for (int k = 1; k <= DLY; k++) begin
      @(posedge clk); #1;
      if (k == DLY - 1) chk("R6 early", {31'd0, acc_ready}, 0);
      if (k == DLY)     chk("R6 on time", {31'd0, acc_ready}, 1);
    end
    s_rd(12'hF88, v); chk("R6 req read", v, 1);
    s_rd(12'hF8C, v); chk("R6 rdy read", v, 1);
    // R8 ready rise latched
    s_rd(12'hF90, v); chk("R8 int_st", v, 1);
    chk("R8 irq off", {31'd0, snd_irq}, 0);
    s_wr(12'hF98, 1);
    chk("R8 irq on", {31'd0, snd_irq}, 1);
    s_rd(12'hF98, v); chk("R8 int_en", v, 1);
    s_wr(12'hF94, 1);
    chk("R8 irq cleared", {31'd0, snd_irq}, 0);
    s_rd(12'hF90, v); chk("R8 int_st clr", v, 0);

    // R2 sweep of set patterns over every channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int p = 0; p < 8; p++) begin
        logic [31:0] d;
        d = (32'h1 << (ch * 8 + p)) | (32'h0050_0000 >> p);
        s_wr(win(ch, 'h0C), d);
        e_st[ch] = model_upd(e_st[ch], d, 0);
        s_rd(win(ch, 'h00), v); chk("R2 set", v, e_st[ch]);
      end
    end
    check_all("R2 sweep");

    // R4 masks
    for (int ch = 0; ch < NCH; ch++) begin
      r_wr(win(ch, 'h14), 32'hFFFF_FFFF >> (ch * 9));
      e_mk[ch] = 32'hFFFF_FFFF >> (ch * 9);
      r_wr(win(ch, 'h18), 32'h0000_00F0);
      e_mk[ch] = e_mk[ch] & ~32'hF0;
    end
    check_all("R4 mask");

    // R3 partial clears
    for (int ch = 0; ch < NCH; ch++) begin
      logic [31:0] c;
      c = 32'h00FF_00FF << ch;
      r_wr(win(ch, 'h08), c);
      e_st[ch] = model_upd(e_st[ch], 0, c);
    end
    check_all("R3 partial");

    // R3 same-cycle set and clear, clear wins on overlap
    both_wr(win(2, 'h0C), 32'hF0F0_F0F0, win(2, 'h08), 32'hFF00_FF00);
    e_st[2] = model_upd(e_st[2], 32'hF0F0_F0F0, 32'hFF00_FF00);
    r_rd(win(2, 'h00), v); chk("R3 collide", v, e_st[2]);

    // R9 reserved offsets and missing channel
    s_rd(win(0, 'h04), v); chk("R9 snd rsvd", v, 0);
    r_rd(win(0, 'h0C), v); chk("R9 rcv rsvd", v, 0);
    s_rd(win(NCH, 'h00), v); chk("R9 missing ch", v, 0);
    r_rd(12'hF90, v); chk("R9 rcv f90", v, 0);
    s_wr(win(NCH, 'h0C), 32'hFFFF_FFFF);
    s_wr(win(0, 'h00), 32'hFFFF_FFFF);
    s_wr(12'hF80, 32'h55);
    r_wr(win(NCH, 'h08), 32'hFFFF_FFFF);
    r_wr(win(1, 'h1C), 32'hFFFF_FFFF);
    s_rd(12'hF80, v); chk("R9 cfg kept", v, NCH);
    check_all("R9 ignored");

    // R5 / R3: unmask one channel then clear all ones everywhere
    r_wr(win(3, 'h18), 32'hFFFF_FFFF);
    e_mk[3] = 0;
    check_all("R5 unmask");
    for (int ch = 0; ch < NCH; ch++) begin
      r_wr(win(ch, 'h08), 32'hFFFF_FFFF);
      e_st[ch] = 0;
    end
    check_all("R3 all ones");
    chk("R5 idle", {31'd0, rcv_irq}, 0);

    // R6 release
    s_wr(12'hF88, 0);
    chk("R6 release", {31'd0, acc_ready}, 0);
    s_wr(win(0, 'h0C), 32'h1);
    r_rd(win(0, 'h00), v); chk("R2 gated after release", v, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule